// File: doc/BRIEF.md
# Register Spill Engine with Deferred-Exception Bit Collection

This engine moves stacked registers between a register file and a backing store in memory. Each register is 65 bits wide: 64 data bits plus one deferred-exception bit. Memory holds 64-bit words, so the data goes into the memory stream and the extra bit is set aside. The extra bits gather in a collection register. One slot in every 64 doubleword slots of the backing store holds that collection word, and the word there covers the 63 registers stored just below it.

An upstream requester starts a transfer with a direction, a base register index and a register count. A spill stores registers in ascending index order at rising addresses, and the store pointer moves up one word per access. A fill is the exact reverse. The pointer moves down one word before each read. Registers come back in descending index order, and the collection word of a group is reloaded before any register of that group is restored. Memory uses a simple request/acknowledge port with one access in flight. The store pointer can be relocated while the engine is idle.

Top module: `spill_engine`

## Requirements
- R1: After reset the engine is idle (busy and memReq low), storePtr equals the reset parameter (0 by default) and the collection register is all zeros.
- R2: A spill writes register reqBase, then reqBase+1 and so on. Each word goes to the current storePtr, and storePtr rises by 8 on every acknowledged word.
- R3: When bits 8:3 of the spill address are 6'b111111, that access writes the collection word in place of a register. The pointer still advances, and the slot does not count towards the request.
- R4: A register stored at address A has its deferred-exception bit recorded in collection bit A[8:3], so bit 0 belongs to the earliest register of the group and bit 62 to the last. Bit 63 of a written collection word is always 0.
- R5: The collection register is cleared in the cycle after a spill's collection word is acknowledged.
- R6: A fill reads from storePtr-8 and lowers storePtr by 8 per acknowledged word. It restores registers reqBase+reqCount-1 down to reqBase, each with the read data and the collection bit selected by address bits 8:3.
- R7: When a fill reaches a slot whose bits 8:3 are all ones, the word read there is loaded into the collection register. No register write happens for that slot, and the slot is not counted.
- R8: busy rises in the cycle after a request with a non-zero count is accepted and falls after the acknowledge of the last counted access. memReq equals busy. An unacknowledged request holds its address and direction.
- R9: A request with reqCount of 0 is ignored and busy stays low.
- R10: ptrLoad loads storePtr with ptrLoadVal with its low 3 bits cleared, but only while idle. A ptrLoad during a transfer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transfer request, accepted when idle |
| reqFill | input | 1 | 1 = fill (memory to registers), 0 = spill |
| reqBase | input | IDX_W | Lowest register index of the transfer |
| reqCount | input | CNT_W | Number of registers to move |
| ptrLoad | input | 1 | Relocate the store pointer (idle only) |
| ptrLoadVal | input | ADDR_W | New store pointer value |
| busy | output | 1 | Transfer in progress |
| rfRdIdx | output | IDX_W | Register file read index for spills |
| rfRdData | input | DATA_W | Register data at rfRdIdx |
| rfRdNat | input | 1 | Deferred-exception bit at rfRdIdx |
| rfWrEn | output | 1 | Register file write strobe for fills |
| rfWrIdx | output | IDX_W | Register index written |
| rfWrData | output | DATA_W | Restored data |
| rfWrNat | output | 1 | Restored deferred-exception bit |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Byte address of the access |
| memWdata | output | DATA_W | Write data |
| memAck | input | 1 | Access completes this cycle |
| memRdata | input | DATA_W | Read data, valid with memAck |
| storePtr | output | ADDR_W | Current store pointer |
| natColl | output | DATA_W | Collection register |

## Verification
The bench starts spills from pointers a few slots below a collection slot, so that the transfer crosses one. A design that counted that slot as a register would end the spill one register early, and one that put the wrong bit at 63 or forgot the clear would write wrong collection words. Fills run back across the same slot, so a late reload, or one that skipped the slot, restores wrong deferred-exception bits. One spill starts exactly on a collection slot and is filled back while its group is still only in the register, which catches a design that reloads too eagerly. Memory acknowledges arrive after random delays, which catches a pointer that moves on request rather than on acknowledge. Zero-count requests and a relocation during a transfer are also sent, to check that both are ignored.

// File: rtl/spill_pkg.sv
package spill_pkg;
  // strobes from the sequencer to the pointer/collection datapath
  typedef struct packed {
    logic active;  // a transfer is in progress
    logic fill;    // direction of the transfer in progress
    logic step;    // the current memory access completes this cycle
  } ctlStrobe_t;
endpackage

// File: rtl/spill_ctrl.sv
module spill_ctrl
  import spill_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             reqFill,
  input  logic [IDX_W-1:0] reqBase,
  input  logic [CNT_W-1:0] reqCount,
  input  logic             memAck,
  input  logic             collSlot,
  output ctlStrobe_t       strobe,
  output logic             busy,
  output logic             memReq,
  output logic             memWe,
  output logic [IDX_W-1:0] rfRdIdx,
  output logic             rfWrEn,
  output logic [IDX_W-1:0] rfWrIdx
);
  logic             busyQ;
  logic             fillQ;
  logic [CNT_W-1:0] remainQ;
  logic [IDX_W-1:0] regIdxQ;
  logic [IDX_W-1:0] lastIdx;
  logic             accept;
  logic             countStep;

  assign lastIdx   = reqBase + IDX_W'(reqCount) - IDX_W'(1);
  assign accept    = !busyQ && reqValid && (reqCount != '0);
  assign countStep = busyQ && memAck && !collSlot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ   <= 1'b0;
      fillQ   <= 1'b0;
      remainQ <= '0;
      regIdxQ <= '0;
    end else if (accept) begin
      busyQ   <= 1'b1;
      fillQ   <= reqFill;
      remainQ <= reqCount;
      regIdxQ <= reqFill ? lastIdx : reqBase;
    end else if (countStep) begin
      remainQ <= remainQ - CNT_W'(1);
      regIdxQ <= fillQ ? regIdxQ - IDX_W'(1) : regIdxQ + IDX_W'(1);
      if (remainQ == CNT_W'(1)) busyQ <= 1'b0;
    end
  end

  assign strobe.active = busyQ;
  assign strobe.fill   = fillQ;
  assign strobe.step   = busyQ && memAck;

  assign busy    = busyQ;
  assign memReq  = busyQ;
  assign memWe   = busyQ && !fillQ;
  assign rfRdIdx = regIdxQ;
  assign rfWrIdx = regIdxQ;
  assign rfWrEn  = countStep && fillQ;
endmodule

// File: rtl/spill_dpath.sv
module spill_dpath
  import spill_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              DATA_W    = 64,
  parameter logic [ADDR_W-1:0] PTR_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  input  logic              ptrLoad,
  input  logic [ADDR_W-1:0] ptrLoadVal,
  input  logic [DATA_W-1:0] rfRdData,
  input  logic              rfRdNat,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              collSlot,
  output logic [DATA_W-1:0] rfWrData,
  output logic              rfWrNat,
  output logic [ADDR_W-1:0] storePtr,
  output logic [DATA_W-1:0] natColl
);
  localparam int BYTE_SH = $clog2(DATA_W / 8);
  localparam int SLOT_W  = $clog2(DATA_W);
  localparam int SLOT_HI = BYTE_SH + SLOT_W - 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  logic [ADDR_W-1:0] ptrQ;
  logic [DATA_W-1:0] collQ;
  logic [ADDR_W-1:0] accAddr;
  logic [SLOT_W-1:0] slotIdx;

  // a fill reads the word just below the pointer, a spill writes at it
  assign accAddr  = strobe.fill ? ptrQ - STEP : ptrQ;
  assign slotIdx  = accAddr[SLOT_HI:BYTE_SH];
  assign collSlot = &slotIdx;

  assign memAddr  = accAddr;
  assign memWdata = collSlot ? {1'b0, collQ[DATA_W-2:0]} : rfRdData;
  assign rfWrData = memRdata;
  assign rfWrNat  = collQ[slotIdx];
  assign storePtr = ptrQ;
  assign natColl  = collQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptrQ  <= PTR_RESET;
      collQ <= '0;
    end else if (!strobe.active) begin
      if (ptrLoad) ptrQ <= {ptrLoadVal[ADDR_W-1:BYTE_SH], BYTE_SH'(0)};
    end else if (strobe.step) begin
      if (strobe.fill) begin
        ptrQ <= ptrQ - STEP;
        if (collSlot) collQ <= memRdata;
      end else begin
        ptrQ <= ptrQ + STEP;
        if (collSlot) collQ <= '0;
        else          collQ[slotIdx] <= rfRdNat;
      end
    end
  end
endmodule

// File: rtl/spill_engine.sv
module spill_engine
  import spill_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              DATA_W    = 64,
  parameter int              NREG      = 96,
  parameter logic [ADDR_W-1:0] PTR_RESET = '0,
  localparam int             IDX_W     = $clog2(NREG),
  localparam int             CNT_W     = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqFill,
  input  logic [IDX_W-1:0]  reqBase,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic              ptrLoad,
  input  logic [ADDR_W-1:0] ptrLoadVal,
  output logic              busy,
  output logic [IDX_W-1:0]  rfRdIdx,
  input  logic [DATA_W-1:0] rfRdData,
  input  logic              rfRdNat,
  output logic              rfWrEn,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [DATA_W-1:0] rfWrData,
  output logic              rfWrNat,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] storePtr,
  output logic [DATA_W-1:0] natColl
);
  ctlStrobe_t strobe;
  logic       collSlot;

  spill_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqFill(reqFill),
    .reqBase(reqBase), .reqCount(reqCount), .memAck(memAck),
    .collSlot(collSlot), .strobe(strobe), .busy(busy), .memReq(memReq),
    .memWe(memWe), .rfRdIdx(rfRdIdx), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx)
  );

  spill_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_RESET(PTR_RESET)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .ptrLoad(ptrLoad),
    .ptrLoadVal(ptrLoadVal), .rfRdData(rfRdData), .rfRdNat(rfRdNat),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .collSlot(collSlot), .rfWrData(rfWrData), .rfWrNat(rfWrNat),
    .storePtr(storePtr), .natColl(natColl)
  );
endmodule

// File: rtl/spill_chk.sv
module spill_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ptrLoad,
  input logic              rfWrEn,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memAck,
  input logic [ADDR_W-1:0] storePtr,
  input logic [DATA_W-1:0] natColl
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  // R8
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> busy);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R2
  ptr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memWe && memAck) |=> (storePtr == $past(storePtr) + STEP));

  // R6
  ptr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memWe && memAck) |=> (storePtr == $past(storePtr) - STEP));

  // R4
  coll_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memWe && (&memAddr[8:3])) |-> !memWdata[63]);

  // R5
  coll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memWe && memAck && (&memAddr[8:3])) |=> (natColl == '0));

  // R7
  no_rf_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfWrEn |-> (memReq && !memWe && !(&memAddr[8:3])));

  // R10
  idle_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ptrLoad) |=> $stable(storePtr));
endmodule

bind spill_engine spill_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ptrLoad(ptrLoad), .rfWrEn(rfWrEn),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
  .memAck(memAck), .storePtr(storePtr), .natColl(natColl)
);

// File: tb/sim_spill_engine.sv
`timescale 1ns/1ps
module sim_spill_engine;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int NREG   = 96;
  localparam int IDX_W  = $clog2(NREG);
  localparam int CNT_W  = $clog2(NREG + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqFill = 1'b0;
  logic [IDX_W-1:0]  reqBase = '0;
  logic [CNT_W-1:0]  reqCount = '0;
  logic              ptrLoad = 1'b0;
  logic [ADDR_W-1:0] ptrLoadVal = '0;
  logic              busy;
  logic [IDX_W-1:0]  rfRdIdx;
  logic [DATA_W-1:0] rfRdData;
  logic              rfRdNat;
  logic              rfWrEn;
  logic [IDX_W-1:0]  rfWrIdx;
  logic [DATA_W-1:0] rfWrData;
  logic              rfWrNat;
  logic              memReq;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic              memAck = 1'b0;
  logic [DATA_W-1:0] memRdata = '0;
  logic [ADDR_W-1:0] storePtr;
  logic [DATA_W-1:0] natColl;

  always #2.5 clk = ~clk;

  // register file contents supplied to the engine (written only by the stimulus)
  logic [DATA_W-1:0] rfD [NREG];
  logic              rfN [NREG];
  // values the engine restored
  logic [DATA_W-1:0] restD [NREG];
  logic              restN [NREG];

  assign rfRdData = rfD[rfRdIdx];
  assign rfRdNat  = rfN[rfRdIdx];

  spill_engine u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqFill(reqFill),
    .reqBase(reqBase), .reqCount(reqCount), .ptrLoad(ptrLoad),
    .ptrLoadVal(ptrLoadVal), .busy(busy), .rfRdIdx(rfRdIdx),
    .rfRdData(rfRdData), .rfRdNat(rfRdNat), .rfWrEn(rfWrEn),
    .rfWrIdx(rfWrIdx), .rfWrData(rfWrData), .rfWrNat(rfWrNat),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .storePtr(storePtr),
    .natColl(natColl)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit                mBusy = 0;
  bit                mFill = 0;
  int                mRemain = 0;
  int                mIdx = 0;
  logic [ADDR_W-1:0] mPtr = '0;
  logic [DATA_W-1:0] mColl = '0;
  logic [DATA_W-1:0] modelMem [logic [ADDR_W-1:0]];

  function automatic logic [ADDR_W-1:0] mAddr();
    return mFill ? mPtr - 32'd8 : mPtr;
  endfunction

  function automatic logic [DATA_W-1:0] memAt(input logic [ADDR_W-1:0] a);
    return modelMem.exists(a) ? modelMem[a] : '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mBusy = 0; mFill = 0; mRemain = 0; mIdx = 0; mPtr = '0; mColl = '0;
    end else if (!mBusy) begin
      if (ptrLoad) mPtr = {ptrLoadVal[ADDR_W-1:3], 3'b000};
      if (reqValid && reqCount != 0) begin
        mBusy = 1; mFill = reqFill; mRemain = int'(reqCount);
        mIdx = reqFill ? int'(reqBase) + int'(reqCount) - 1 : int'(reqBase);
      end
    end else if (memAck) begin
      logic [ADDR_W-1:0] a;
      bit isColl;
      a = mAddr();
      isColl = (a[8:3] == 6'h3f);
      if (mFill) begin
        if (isColl) mColl = memAt(a);
        else begin
          restD[mIdx] <= memAt(a);
          restN[mIdx] <= mColl[a[8:3]];
        end
        mPtr = mPtr - 32'd8;
      end else begin
        if (isColl) begin
          modelMem[a] = {1'b0, mColl[62:0]};
          mColl = '0;
        end else begin
          modelMem[a] = rfD[mIdx];
          mColl[a[8:3]] = rfN[mIdx];
        end
        mPtr = mPtr + 32'd8;
      end
      if (!isColl) begin
        mRemain--;
        mIdx = mFill ? mIdx - 1 : mIdx + 1;
        if (mRemain == 0) mBusy = 0;
      end
    end
  end

  // ---------------- memory responder ----------------
  logic [DATA_W-1:0] mem [logic [ADDR_W-1:0]];
  int waitCnt = 0;
  always @(negedge clk) begin
    memAck = 1'b0;
    if (rst_n && memReq) begin
      if (waitCnt == 0) begin
        memAck = 1'b1;
        waitCnt = int'($urandom % 3);
        if (memWe) mem[memAddr] = memWdata;
        else memRdata = mem.exists(memAddr) ? mem[memAddr] : '0;
      end else begin
        waitCnt--;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    #1;
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n) begin
      logic [ADDR_W-1:0] a;
      bit isColl;
      bit eWr;
      a = mAddr();
      isColl = (a[8:3] == 6'h3f);
      chk("R8 R9 busy", 64'(busy), 64'(mBusy));
      chk("R8 memReq", 64'(memReq), 64'(mBusy));
      chk("R2 R10 storePtr", 64'(storePtr), 64'(mPtr));
      chk("R4 R5 R7 natColl", natColl, mColl);
      if (mBusy) begin
        chk("R2 R6 memAddr", 64'(memAddr), 64'(a));
        chk("R8 memWe", 64'(memWe), 64'(!mFill));
        if (!mFill)
          chk("R3 R4 memWdata", memWdata,
              isColl ? {1'b0, mColl[62:0]} : rfD[mIdx]);
      end
      eWr = mBusy && mFill && memAck && !isColl;
      chk("R6 R7 rfWrEn", 64'(rfWrEn), 64'(eWr));
      if (eWr) begin
        chk("R6 rfWrIdx", 64'(rfWrIdx), 64'(mIdx));
        chk("R6 rfWrData", rfWrData, memAt(a));
        chk("R4 R6 rfWrNat", 64'(rfWrNat), 64'(mColl[a[8:3]]));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic sendReq(input bit fill, input int base, input int cnt);
    @(negedge clk);
    reqValid = 1'b1; reqFill = fill;
    reqBase = IDX_W'(base); reqCount = CNT_W'(cnt);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic loadPtr(input logic [ADDR_W-1:0] v);
    @(negedge clk);
    ptrLoad = 1'b1; ptrLoadVal = v;
    @(negedge clk);
    ptrLoad = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic cmpRestore(input int base, input int cnt);
    @(negedge clk);
    for (int i = base; i < base + cnt; i++) begin
      checks++;
      if (restD[i] !== rfD[i] || restN[i] !== rfN[i]) begin
        errors++;
        $display("FAIL R6 R7 restored reg %0d actual %h/%0b expected %h/%0b",
                 i, restD[i], restN[i], rfD[i], rfN[i]);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) begin
      rfD[i] = {$urandom, $urandom};
      rfN[i] = 1'($urandom % 2);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 memReq", 64'(memReq), 64'd0);
    chk("R1 storePtr", 64'(storePtr), 64'd0);
    chk("R1 natColl", natColl, 64'd0);

    // R9 zero-count request is ignored
    sendReq(1'b0, 5, 0);
    repeat (2) @(negedge clk);

    // R10 unaligned relocation, slot 58 of a group
    loadPtr(32'h0000_11D3);

    // spill across a collection slot, with an ignored relocation mid-transfer (R10)
    sendReq(1'b0, 10, 20);
    repeat (3) @(negedge clk);
    loadPtr(32'h0000_5000);
    waitIdle();
    sendReq(1'b1, 10, 20);
    waitIdle();
    cmpRestore(10, 20);

    // long spill from a group start, then fill it back (R3 R7)
    loadPtr(32'h0000_2000);
    sendReq(1'b0, 0, 70);
    waitIdle();
    sendReq(1'b1, 0, 70);
    waitIdle();
    cmpRestore(0, 70);

    // spill starting on a collection slot; fill uses the live collection (R3 R6)
    loadPtr(32'h0000_31F8);
    sendReq(1'b0, 40, 3);
    waitIdle();
    sendReq(1'b1, 40, 3);
    waitIdle();
    cmpRestore(40, 3);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule